// File: doc/BRIEF.md
# Paging Preamble Detector with Edge-Error Counting

The block looks for the alternating 1,0 lead-in of a paging signal on an oversampled receive line. The line is sampled once per clock, eight samples to a bit period. A separate strobe, `bitTick`, marks the last sample of each bit period. Every bit period that holds two or more level changes counts as one edge error. The errors are summed over a window of bit periods whose length can be programmed.

At the end of each window the block decides whether a preamble was present. Two things must both be true. First, every 1,0 cycle in the window showed both a rising and a falling edge. Second, the window's error total stayed at or below a threshold chosen by a 3-bit select. The pair test checks for the presence of both edges and does not look at where they fall, so duty factors from 25% to 75% are accepted. A narrow high pulse that puts both edges inside one bit period still counts as an edge error. A rate-error flag follows the running count. The count is also brought out, and it clears when each window closes.

Top module: `preamble_detect`

## Requirements
- R1: While `rstN` is low and in the first cycle after release, `preambleDet`, `rateErr` and `errCount` are all 0.
- R2: An edge is a change of `rxData` between consecutive clock samples; the level before the first sample after reset is taken as 0. A bit period runs from the sample after one `bitTick` up to and including the sample with the next `bitTick`. A period holding two or more edges is one edge error.
- R3: `errCount` rises by exactly one on each `bitTick` that closes an erroneous bit period and saturates at 15. It changes only in the cycle after a `bitTick`.
- R4: `rateErr` is 1 exactly while `errCount` is greater than `thrSel`+1, so the threshold runs from 1 to 8 errors.
- R5: A window is 2×`winCycles` bit periods (`winCycles` from 3 to 272, so 6 to 544 bits). Its bit periods are grouped into pairs from the window start. A pair passes when it contains at least one rising edge and at least one falling edge.
- R6: `preambleDet` is a one-cycle pulse in the cycle after the `bitTick` that closes a window. It pulses only if every pair of the window passed and the window's error total, including that final bit period, is at most `thrSel`+1. It is 0 in every other cycle.
- R7: A 1,0 waveform whose high portion covers anything from 4 to 12 of the 16 samples of a cycle passes every pair. A high portion of 8 samples at any phase produces no edge errors.
- R8: When a window closes, `errCount` returns to 0 and a new window starts at once. Back-to-back windows are each judged on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one receive sample per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxData | input | 1 | Oversampled receive line |
| bitTick | input | 1 | High on the last sample of each bit period |
| thrSel | input | 3 | Threshold select; n allows n+1 errors |
| winCycles | input | 9 | Window length in 1,0 cycles (two bit periods each) |
| preambleDet | output | 1 | One-cycle pulse: preamble found in the window just closed |
| rateErr | output | 1 | Error count above threshold |
| errCount | output | 4 | Errors counted so far in the current window |

## Verification
The counter update for the last bit period and the close of the window fall on the same `bitTick`. That final error must be counted into the decision, and the count must still be cleared for the next window. This is provoked with a glitchy pattern that puts an error in every cycle. With the threshold at 8, a window of eight cycles must still pulse `preambleDet`, and a window of nine must not. The result is judged by the pulse value and by `errCount` being 0 right after the close and 1 after the first bit of the following window.

// File: rtl/pdet_pkg.sv
package pdet_pkg;
  // strobes from control to datapath, all qualified by bitTick
  typedef struct packed {
    logic bitClose;   // last sample of a bit period
    logic pairClose;  // last sample of the second bit of a 1,0 pair
    logic winEnd;     // last sample of the window
  } pdetStrb_t;
endpackage

// File: rtl/pdet_dp.sv
module pdet_dp
  import pdet_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int WIN_W = 9,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxData,
  input  logic [THR_W-1:0] thrSel,
  input  logic [WIN_W-1:0] winCycles,
  input  pdetStrb_t        strb,
  output logic             pairGood,
  output logic             winHit,
  output logic             errOk,
  output logic             rateErr,
  output logic [CNT_W-1:0] errCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int WIN_X = WIN_W + 1;

  logic             prevRx;
  logic [1:0]       edgeCnt;
  logic [1:0]       edgeTot;
  logic             riseSeen, fallSeen;
  logic [WIN_W-1:0] cycCnt;
  logic [CNT_W-1:0] errCnt, errNext, thrVal;
  logic             edgeNow, riseNow, fallNow, bitErr;

  assign edgeNow = rxData ^ prevRx;
  assign riseNow = rxData & ~prevRx;
  assign fallNow = ~rxData & prevRx;

  always_comb begin
    if (edgeCnt == 2'd2) edgeTot = 2'd2;
    else                 edgeTot = edgeCnt + {1'b0, edgeNow};
  end

  assign bitErr   = strb.bitClose && (edgeTot == 2'd2);
  assign errNext  = (errCnt == CNT_MAX) ? errCnt : errCnt + CNT_W'(bitErr);
  assign thrVal   = CNT_W'(thrSel) + CNT_W'(1);
  assign errOk    = (errNext <= thrVal);
  assign rateErr  = (errCnt > thrVal);
  assign errCount = errCnt;
  assign pairGood = (riseSeen | riseNow) & (fallSeen | fallNow);
  assign winHit   = (WIN_X'(cycCnt) + WIN_X'(1)) == WIN_X'(winCycles);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRx   <= 1'b0;
      edgeCnt  <= '0;
      riseSeen <= 1'b0;
      fallSeen <= 1'b0;
      cycCnt   <= '0;
      errCnt   <= '0;
    end else begin
      prevRx  <= rxData;
      edgeCnt <= strb.bitClose ? 2'd0 : edgeTot;
      if (strb.pairClose) begin
        riseSeen <= 1'b0;
        fallSeen <= 1'b0;
      end else begin
        riseSeen <= riseSeen | riseNow;
        fallSeen <= fallSeen | fallNow;
      end
      if (strb.winEnd)         cycCnt <= '0;
      else if (strb.pairClose) cycCnt <= cycCnt + WIN_W'(1);
      if (strb.winEnd)         errCnt <= '0;
      else if (strb.bitClose)  errCnt <= errNext;
    end
  end
endmodule

// File: rtl/pdet_ctl.sv
module pdet_ctl
  import pdet_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      pairGood,
  input  logic      winHit,
  input  logic      errOk,
  output pdetStrb_t strb,
  output logic      preambleDet
);
  logic phase;    // 0: first bit of a pair, 1: second bit
  logic allGood;  // every closed pair of this window passed

  always_comb begin
    strb.bitClose  = bitTick;
    strb.pairClose = bitTick & phase;
    strb.winEnd    = bitTick & phase & winHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase       <= 1'b0;
      allGood     <= 1'b1;
      preambleDet <= 1'b0;
    end else begin
      if (bitTick) phase <= ~phase;
      if (strb.winEnd)         allGood <= 1'b1;
      else if (strb.pairClose) allGood <= allGood & pairGood;
      preambleDet <= strb.winEnd & allGood & pairGood & errOk;
    end
  end
endmodule

// File: rtl/preamble_detect.sv
module preamble_detect
  import pdet_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int WIN_W = 9,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxData,
  input  logic             bitTick,
  input  logic [THR_W-1:0] thrSel,
  input  logic [WIN_W-1:0] winCycles,
  output logic             preambleDet,
  output logic             rateErr,
  output logic [CNT_W-1:0] errCount
);
  pdetStrb_t strb;
  logic      pairGood, winHit, errOk;

  pdet_ctl u_ctl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .pairGood(pairGood),
    .winHit(winHit), .errOk(errOk), .strb(strb), .preambleDet(preambleDet)
  );

  pdet_dp #(.CNT_W(CNT_W), .WIN_W(WIN_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxData(rxData), .thrSel(thrSel),
    .winCycles(winCycles), .strb(strb), .pairGood(pairGood),
    .winHit(winHit), .errOk(errOk), .rateErr(rateErr), .errCount(errCount)
  );
endmodule

// File: rtl/pdet_chk.sv
module pdet_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bitTick,
  input logic             preambleDet,
  input logic             rateErr,
  input logic [CNT_W-1:0] errCount
);
  AST_DET_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    preambleDet |-> $past(bitTick)); // R6
  AST_DET_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    preambleDet |=> !preambleDet); // R6
  AST_DET_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rstN)
    preambleDet |-> errCount == '0); // R8
  AST_CNT_AT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> $stable(errCount)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (errCount != '0 && errCount != $past(errCount)) |-> errCount == $past(errCount) + CNT_W'(1)); // R3
  AST_RATE_MIN: assert property (@(posedge clk) disable iff (!rstN)
    rateErr |-> errCount > CNT_W'(1)); // R4
endmodule

bind preamble_detect pdet_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .preambleDet(preambleDet),
  .rateErr(rateErr), .errCount(errCount)
);

// File: tb/sim_preamble_detect.sv
`timescale 1ns/1ps
module sim_preamble_detect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxData = 1'b0;
  logic       bitTick = 1'b0;
  logic [2:0] thrSel = 3'd0;
  logic [8:0] winCycles = 9'd3;
  logic       preambleDet, rateErr;
  logic [3:0] errCount;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  preamble_detect u0 (
    .clk(clk), .rstN(rstN), .rxData(rxData), .bitTick(bitTick),
    .thrSel(thrSel), .winCycles(winCycles),
    .preambleDet(preambleDet), .rateErr(rateErr), .errCount(errCount)
  );

  // {thrSel[3], winCycles[9], pattern[16], expDet, expCnt after win-1 cycles[4]}
  localparam int NV = 9;
  localparam logic [32:0] VEC [NV] = '{
    {3'd0, 9'd3, 16'hFF00, 1'b1, 4'd0},  // R5 R6 50% duty
    {3'd0, 9'd3, 16'hFFF0, 1'b1, 4'd0},  // R7 75% duty
    {3'd2, 9'd3, 16'hF000, 1'b1, 4'd2},  // R7 25% duty, 3 errors <= 3
    {3'd1, 9'd3, 16'hF000, 1'b0, 4'd2},  // R6 3 errors > 2
    {3'd7, 9'd8, 16'hAA00, 1'b1, 4'd7},  // R2 R6 8 errors <= 8
    {3'd7, 9'd9, 16'hAA00, 1'b0, 4'd8},  // R6 9 errors > 8
    {3'd7, 9'd4, 16'h0000, 1'b0, 4'd0},  // R5 no edges
    {3'd7, 9'd4, 16'hFFFF, 1'b0, 4'd0},  // R5 no falling edge
    {3'd0, 9'd5, 16'h0FF0, 1'b1, 4'd0}   // R7 shifted phase
  };

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; rxData = 1'b0; bitTick = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic drive(input logic v, input logic t);
    rxData = v; bitTick = t;
    @(negedge clk);
  endtask

  task automatic runCycle(input logic [15:0] pat);
    for (int s = 0; s < 16; s++) drive(pat[15-s], (s == 7) || (s == 15));
    rxData = 1'b0; bitTick = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 during and right after reset
    repeat (2) @(negedge clk);
    chk("R1 det in reset", int'(preambleDet), 0);
    chk("R1 cnt in reset", int'(errCount), 0);
    chk("R1 rate in reset", int'(rateErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 det after reset", int'(preambleDet), 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      int w;
      v = VEC[i];
      thrSel = v[32:30]; winCycles = v[29:21]; w = int'(v[29:21]);
      doReset();
      for (int c = 1; c <= w; c++) begin
        runCycle(v[20:5]);
        if (c == w - 1) begin
          chk("R3 vec count", int'(errCount), int'(v[3:0]));
          chk("R6 vec no early det", int'(preambleDet), 0);
        end
        if (c == w) begin
          chk("R6 vec det", int'(preambleDet), int'(v[4]));
          chk("R8 vec count cleared", int'(errCount), 0);
        end
      end
    end

    // R2 R3 count changes only at the closing tick
    thrSel = 3'd7; winCycles = 9'd20;
    doReset();
    for (int s = 0; s < 7; s++) drive((s < 4), 1'b0);
    chk("R3 no change before tick", int'(errCount), 0);
    drive(1'b0, 1'b1);
    chk("R2 error at tick", int'(errCount), 1);
    for (int s = 8; s < 16; s++) drive(1'b0, s == 15);
    chk("R2 clean bit adds nothing", int'(errCount), 1);
    chk("R4 rate off at thr 8", int'(rateErr), 0);
    // R3 saturation
    for (int c = 2; c <= 17; c++) runCycle(16'hF000);
    chk("R3 saturate at 15", int'(errCount), 15);
    chk("R4 rate on above 8", int'(rateErr), 1);

    // R4 threshold 2
    thrSel = 3'd1; winCycles = 9'd10;
    doReset();
    runCycle(16'hF000); runCycle(16'hF000);
    chk("R4 rate off at 2 errors", int'(rateErr), 0);
    runCycle(16'hF000);
    chk("R4 rate on at 3 errors", int'(rateErr), 1);

    // R8 back-to-back windows
    thrSel = 3'd7; winCycles = 9'd3;
    doReset();
    for (int c = 0; c < 3; c++) runCycle(16'hF000);
    chk("R8 first window det", int'(preambleDet), 1);
    chk("R8 count cleared", int'(errCount), 0);
    for (int s = 0; s < 8; s++) drive((s < 4), s == 7);
    chk("R8 new window counts", int'(errCount), 1);
    chk("R6 det is a pulse", int'(preambleDet), 0);
    for (int s = 8; s < 16; s++) drive(1'b0, s == 15);
    runCycle(16'hF000); runCycle(16'hF000);
    chk("R8 second window det", int'(preambleDet), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule